// File: doc/BRIEF.md
# Nonlinear Volume Code Ramper

This block sits between the volume setting of one audio channel and the gain control of that channel's attenuator. It takes an 8-bit volume byte, of which only the low six bits hold the requested gain code, and produces the gain code that is currently applied. Alongside that code it reports a mute flag, the channel gain in dB and the total gain in dB, which adds the input preamplifier.

The gain codes do not map linearly to dB. Code 0 mutes the channel. The first few codes above mute are 6 dB apart. The next group is 3 dB apart, then a group 2 dB apart, and the rest of the range is 1 dB apart, up to +12 dB at code 51. In fast mode the applied code follows the request on the next clock. In slow mode the applied code moves one code at a time toward the request. The step interval is derived from the clock rate and a ramp time parameter, so that a walk across all 51 codes lasts that ramp time.

A shutdown request walks the channel down to mute, and the done flag rises only once mute is reached. One instance is used for each of the speaker channel and the two headset channels.

Top module: `vol_code_ramper`

## Requirements
- R1: Bits 7 and 6 of `vol_byte` have no effect. The requested code is `vol_byte[5:0]`.
- R2: Applied code 0 asserts `mute` and reports `vol_db` = `total_db` = -128. Codes 1, 2 and 3 report -60, -54 and -48 dB.
- R3: Codes 4 to 7 report -45 to -36 dB in 3 dB steps. Codes 8 to 11 report -34 to -28 dB in 2 dB steps.
- R4: Codes 12 to 51 report (code - 39) dB, so code 12 is -27 dB, code 39 is 0 dB and code 51 is +12 dB.
- R5: A requested code above 51 is treated as 51. The applied code never exceeds 51.
- R6: With `fast_en` = 1, the applied code equals the effective target after the next rising clock edge.
- R7: With `fast_en` = 0, the applied code changes by exactly one code toward the target. A change happens once every STEP_CYC clocks, STEP_CYC = CLK_KHZ*RAMP_US/1000/51 (minimum 1). The first step lands STEP_CYC edges after the target moves away from the applied code.
- R8: A new target that arrives during a slow ramp redirects the walk from the current applied code, without a jump.
- R9: `pre_sel` adds 0, +6, +12 or +20 dB for the codes 00, 01, 10 and 11. `total_db` is `vol_db` plus that preamp gain while the channel is not muted.
- R10: While `shut_req` = 1 the target is code 0. `shut_done` is 1 only when `shut_req` = 1 and the applied code is 0. Releasing `shut_req` ramps back to the requested code.
- R11: After synchronous reset the applied code is 0, `mute` is 1 and `shut_done` is 0 while `shut_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vol_byte | input | 8 | Requested volume; bits 5:0 are the gain code |
| pre_sel | input | 2 | Preamplifier gain select |
| fast_en | input | 1 | 1: jump to the target; 0: ramp one code per step |
| shut_req | input | 1 | Shutdown request; forces the target to mute |
| applied_code | output | 6 | Gain code currently applied |
| mute | output | 1 | Channel is muted (applied code 0) |
| vol_db | output | 8 | Signed channel gain in dB, -128 when muted |
| total_db | output | 8 | Signed preamp plus channel gain in dB, -128 when muted |
| shut_done | output | 1 | Shutdown has reached mute |

## Verification
The first pattern sweeps every 6-bit request, with random upper bits, in fast mode. It tells each segment of the dB map apart and shows where clamping begins. A slow ramp is timed edge by edge to check the step interval. A second target arriving halfway through a ramp distinguishes a true redirect from a restart or a jump. A shutdown and release cycle shows that the done flag waits for mute and that the walk then returns to the request. A preamp sweep at 0 dB and at +12 dB separates the four preamp offsets.

// File: rtl/vol_ramp_pkg.sv
package vol_ramp_pkg;

    localparam int CODE_W   = 6;
    localparam int DB_W     = 8;
    localparam int MAX_CODE = 51;
    localparam int MUTE_DB  = -128;

    typedef logic [CODE_W-1:0]      vcode_t;
    typedef logic signed [DB_W-1:0] db_t;

    typedef enum logic [1:0] {
        PRE_0DB  = 2'b00,
        PRE_6DB  = 2'b01,
        PRE_12DB = 2'b10,
        PRE_20DB = 2'b11
    } pre_sel_e;

    typedef struct packed {
        logic mute;
        db_t  vol_db;
        db_t  total_db;
    } gain_rpt_t;

    // Clamp a raw request into the legal code range.
    function automatic vcode_t clamp_code(input vcode_t raw);
        if (int'(raw) > MAX_CODE) return vcode_t'(MAX_CODE);
        return raw;
    endfunction

    // Piecewise map: 6 dB, 3 dB, 2 dB, then 1 dB per code.
    function automatic db_t code_to_db(input vcode_t c);
        int v;
        v = int'(c);
        if (v == 0)       return db_t'(MUTE_DB);
        else if (v < 4)   return db_t'(6 * v - 66);
        else if (v < 8)   return db_t'(3 * v - 57);
        else if (v < 12)  return db_t'(2 * v - 50);
        else              return db_t'(v - 39);
    endfunction

    function automatic db_t pre_to_db(input pre_sel_e p);
        case (p)
            PRE_0DB:  return db_t'(0);
            PRE_6DB:  return db_t'(6);
            PRE_12DB: return db_t'(12);
            default:  return db_t'(20);
        endcase
    endfunction

endpackage

// File: rtl/vol_target_sel.sv
module vol_target_sel
    import vol_ramp_pkg::*;
(
    input  logic [7:0] vol_byte,
    input  logic       shut_req,
    output vcode_t     target
);
    vcode_t req_code;

    always_comb begin
        req_code = clamp_code(vol_byte[CODE_W-1:0]);
        target   = shut_req ? vcode_t'(0) : req_code;
    end
endmodule

// File: rtl/vol_step_timer.sv
module vol_step_timer #(
    parameter int STEP_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

    generate
        if (STEP_CYC <= 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_q;
            localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYC - 1);

            assign tick = run && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run) cnt_q <= '0;
                else if (tick)   cnt_q <= '0;
                else             cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/vol_walker.sv
module vol_walker
    import vol_ramp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fast_en,
    input  logic   tick,
    input  vcode_t target,
    output vcode_t applied,
    output logic   moving
);
    vcode_t cur_q;
    vcode_t nxt;

    assign applied = cur_q;
    assign moving  = (cur_q != target);

    always_comb begin
        nxt = cur_q;
        if (fast_en)
            nxt = target;
        else if (tick && moving)
            nxt = (target > cur_q) ? cur_q + 1'b1 : cur_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end
endmodule

// File: rtl/vol_db_map.sv
module vol_db_map
    import vol_ramp_pkg::*;
(
    input  vcode_t    code,
    input  logic [1:0] pre_sel,
    output gain_rpt_t rpt
);
    db_t vdb;
    db_t pdb;

    always_comb begin
        vdb          = code_to_db(code);
        pdb          = pre_to_db(pre_sel_e'(pre_sel));
        rpt.mute     = (code == '0);
        rpt.vol_db   = vdb;
        rpt.total_db = rpt.mute ? db_t'(MUTE_DB) : vdb + pdb;
    end
endmodule

// File: rtl/vol_code_ramper.sv
module vol_code_ramper
    import vol_ramp_pkg::*;
#(
    parameter int CLK_KHZ = 100000,
    parameter int RAMP_US = 32000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [7:0]             vol_byte,
    input  logic [1:0]             pre_sel,
    input  logic                   fast_en,
    input  logic                   shut_req,
    output logic [CODE_W-1:0]      applied_code,
    output logic                   mute,
    output logic signed [DB_W-1:0] vol_db,
    output logic signed [DB_W-1:0] total_db,
    output logic                   shut_done
);
    localparam longint STEP_RAW = longint'(CLK_KHZ) * longint'(RAMP_US) / 1000 / MAX_CODE;
    localparam int     STEP_CYC = (STEP_RAW < 1) ? 1 : int'(STEP_RAW);

    vcode_t    target;
    vcode_t    applied;
    logic      moving;
    logic      tick;
    gain_rpt_t rpt;

    vol_target_sel u_tsel (
        .vol_byte (vol_byte),
        .shut_req (shut_req),
        .target   (target)
    );

    vol_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (moving && !fast_en),
        .tick (tick)
    );

    vol_walker u_walk (
        .clk     (clk),
        .rst     (rst),
        .fast_en (fast_en),
        .tick    (tick),
        .target  (target),
        .applied (applied),
        .moving  (moving)
    );

    vol_db_map u_map (
        .code    (applied),
        .pre_sel (pre_sel),
        .rpt     (rpt)
    );

    assign applied_code = applied;
    assign mute         = rpt.mute;
    assign vol_db       = rpt.vol_db;
    assign total_db     = rpt.total_db;
    assign shut_done    = shut_req && (applied == '0);
endmodule

// File: rtl/vol_code_ramper_chk.sv
module vol_code_ramper_chk
    import vol_ramp_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [7:0]             vol_byte,
    input logic                   fast_en,
    input logic                   shut_req,
    input logic [CODE_W-1:0]      applied_code,
    input logic                   mute,
    input logic signed [DB_W-1:0] vol_db,
    input logic signed [DB_W-1:0] total_db,
    input logic                   shut_done
);
    p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
        int'(applied_code) <= MAX_CODE);

    p_single_step_r7: assert property (@(posedge clk) disable iff (rst)
        !fast_en |=> (applied_code == $past(applied_code))
                  || ({1'b0, applied_code} == {1'b0, $past(applied_code)} + 7'd1)
                  || ({1'b0, applied_code} + 7'd1 == {1'b0, $past(applied_code)}));

    p_fast_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (fast_en && !shut_req && int'(vol_byte[5:0]) <= MAX_CODE)
            |=> applied_code == $past(vol_byte[5:0]));

    p_done_at_mute_r10: assert property (@(posedge clk) disable iff (rst)
        shut_done |-> (mute && shut_req));

    p_mute_report_r2: assert property (@(posedge clk) disable iff (rst)
        mute |-> (vol_db == -8'sd128 && total_db == -8'sd128));
endmodule

bind vol_code_ramper vol_code_ramper_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vol_byte     (vol_byte),
    .fast_en      (fast_en),
    .shut_req     (shut_req),
    .applied_code (applied_code),
    .mute         (mute),
    .vol_db       (vol_db),
    .total_db     (total_db),
    .shut_done    (shut_done)
);

// File: tb/vol_code_ramper_bench.sv
module vol_code_ramper_bench;
    localparam int CLK_KHZ = 1000;
    localparam int RAMP_US = 1020;
    localparam int STEP    = 20;   // 1000*1020/1000/51

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        vol_byte = 8'd0;
    logic [1:0]        pre_sel = 2'd0;
    logic              fast_en = 1'b0;
    logic              shut_req = 1'b0;
    logic [5:0]        applied_code;
    logic              mute;
    logic signed [7:0] vol_db;
    logic signed [7:0] total_db;
    logic              shut_done;

    int errors = 0;
    int checks = 0;
    int model_code = 0;
    int exp_q[$];
    logic [5:0] last_seen = 6'd0;

    always #5 clk = ~clk;

    vol_code_ramper #(.CLK_KHZ(CLK_KHZ), .RAMP_US(RAMP_US)) u_vol_code_ramper (
        .clk(clk), .rst(rst), .vol_byte(vol_byte), .pre_sel(pre_sel),
        .fast_en(fast_en), .shut_req(shut_req), .applied_code(applied_code),
        .mute(mute), .vol_db(vol_db), .total_db(total_db), .shut_done(shut_done)
    );

    function automatic int ref_db(input int c);
        if (c == 0)  return -128;
        if (c <= 3)  return -60 + 6 * (c - 1);
        if (c <= 7)  return -45 + 3 * (c - 4);
        if (c <= 11) return -34 + 2 * (c - 8);
        return -27 + (c - 12);
    endfunction

    function automatic int ref_pre(input int p);
        case (p)
            0: return 0;
            1: return 6;
            2: return 12;
            default: return 20;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: every change of the applied code must match the queue head.
    always @(negedge clk) begin
        if (!rst && applied_code != last_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected change", int'(applied_code), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(applied_code) == e, "R7 sequence", int'(applied_code), e);
            end
            last_seen = applied_code;
        end
    end

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: computes the expected walk and queues it.
    task automatic go(input logic [7:0] vb);
        int t;
        @(negedge clk);
        vol_byte = vb;
        t = (int'(vb[5:0]) > 51) ? 51 : int'(vb[5:0]);
        if (fast_en) begin
            if (t != model_code) exp_q.push_back(t);
        end else begin
            for (int c = model_code; c != t; ) begin
                c = (t > c) ? c + 1 : c - 1;
                exp_q.push_back(c);
            end
        end
        model_code = t;
        wait_drain();
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(applied_code == 0, "R11 code", int'(applied_code), 0);
        check(mute == 1'b1, "R11 mute", int'(mute), 1);
        check(shut_done == 1'b0, "R11 done", int'(shut_done), 0);
        check(int'(vol_db) == -128, "R2 mute db", int'(vol_db), -128);

        // Fast sweep over all codes with junk in the upper bits (R1..R6)
        fast_en = 1'b1;
        for (int c = 0; c < 64; c++) begin
            int t;
            go({c[1:0] ^ 2'b10, c[5:0]});
            t = (c > 51) ? 51 : c;
            check(int'(applied_code) == t, "R5/R6 clamp and follow", int'(applied_code), t);
            check(int'(vol_db) == ref_db(t), (t < 4) ? "R2 map" : (t < 12) ? "R3 map" : "R4 map",
                  int'(vol_db), ref_db(t));
            check(mute == (t == 0), "R2 mute flag", int'(mute), int'(t == 0));
        end

        // R1: only the upper bits change, nothing moves
        go(8'hF3);   // code 51
        go(8'h33);
        check(int'(applied_code) == 51, "R1 upper bits ignored", int'(applied_code), 51);

        // R9 preamp at +12 dB and at 0 dB
        for (int p = 0; p < 4; p++) begin
            pre_sel = p[1:0];
            @(negedge clk);
            check(int'(total_db) == 12 + ref_pre(p), "R9 total at +12", int'(total_db), 12 + ref_pre(p));
        end
        go(8'd39);
        for (int p = 0; p < 4; p++) begin
            pre_sel = p[1:0];
            @(negedge clk);
            check(int'(total_db) == ref_pre(p), "R9 total at 0 dB", int'(total_db), ref_pre(p));
            check(int'(vol_db) == 0, "R4 code 39", int'(vol_db), 0);
        end
        go(8'd0);
        check(int'(total_db) == -128, "R2 total muted", int'(total_db), -128);
        go(8'd51);

        // R7 slow step timing from 51
        fast_en = 1'b0;
        @(negedge clk);
        vol_byte = 8'd49;
        exp_q.push_back(50);
        exp_q.push_back(49);
        model_code = 49;
        repeat (STEP - 1) @(negedge clk);
        check(int'(applied_code) == 51, "R7 hold before step", int'(applied_code), 51);
        @(negedge clk);
        check(int'(applied_code) == 50, "R7 first step", int'(applied_code), 50);
        repeat (STEP - 1) @(negedge clk);
        check(int'(applied_code) == 50, "R7 hold second", int'(applied_code), 50);
        @(negedge clk);
        check(int'(applied_code) == 49, "R7 second step", int'(applied_code), 49);
        wait_drain();

        // R8 redirect mid-ramp: head for 40, turn back to 60 (clamped 51)
        @(negedge clk);
        vol_byte = 8'd40;
        exp_q.push_back(48);
        exp_q.push_back(47);
        model_code = 47;
        repeat (2 * STEP + 5) @(negedge clk);
        check(int'(applied_code) == 47, "R8 before redirect", int'(applied_code), 47);
        go(8'd60);
        check(int'(applied_code) == 51, "R8 redirected to clamp", int'(applied_code), 51);

        // R10 shutdown ramps down, done waits for mute
        go(8'd4);
        @(negedge clk);
        shut_req = 1'b1;
        for (int c = 3; c >= 0; c--) exp_q.push_back(c);
        repeat (STEP + 2) @(negedge clk);
        check(shut_done == 1'b0, "R10 not done yet", int'(shut_done), 0);
        wait_drain();
        check(shut_done == 1'b1, "R10 done at mute", int'(shut_done), 1);
        check(mute == 1'b1, "R10 muted", int'(mute), 1);
        shut_req = 1'b0;
        for (int c = 1; c <= 4; c++) exp_q.push_back(c);
        @(negedge clk);
        check(shut_done == 1'b0, "R10 done drops", int'(shut_done), 0);
        wait_drain();
        check(int'(applied_code) == 4, "R10 returns to request", int'(applied_code), 4);

        check(exp_q.size() == 0, "R7 queue empty", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule